// File: doc/BRIEF.md
# Paged Core Register Memory

This block is the register and program memory of a small processor core. Instructions name a register with a 9-bit field, so only 512 words of 32 bits are visible at any time. A page register lets several of these 512-word windows share one physical store. Reads, writes and instruction fetches all combine their 9-bit address with the current page number to find the physical word.

A paged jump loads the page register and the program counter in the same cycle. The page number comes from the jump's destination field, which a plain jump does not otherwise use, so no register address is spent on the page register. The top 16 addresses of the window form a block of special registers: an input port, an output port, a direction register and shared scratch words. In the default mode this block is the same storage on every page. A parameter can restrict it to page 0 only.

Top module: `paged_regmem`

## Requirements
- R1: While rst_ni is low, page_o is 0, pc_o is 0, io_out_o is 0 and io_dir_o is 0.
- R2: Addresses 0 to 495 map to physical word page*512 + address. The same address on different pages holds independent values. rd_data_o is combinational from rd_addr_i and the current page, and a write lands on the clock edge.
- R3: When jmp_i is high at a clock edge, page_o takes the page from jmp_page_i and pc_o takes jmp_addr_i. fetch_data_o shows the word at the new page and address directly after that edge.
- R4: When step_i is high and jmp_i is low, pc_o increases by 1 at the edge, wrapping from 511 to 0 with page_o unchanged. With neither high, pc_o and page_o hold.
- R5: A jump page value at or above NUM_PAGES is reduced modulo NUM_PAGES.
- R6: With OVERLAY_ALL=1, addresses 496 to 511 reach the same storage whatever the page: a word written there on one page reads back on any other page.
- R7: Window offset 0 (address 496) reads io_in_i, and writes to it are ignored. Offset 1 (address 497) is the output register driven on io_out_o. Offset 2 (address 498) is the direction register driven on io_dir_o.
- R8: With OVERLAY_ALL=0, the window exists only on page 0. On any other page, addresses 496 to 511 are ordinary page memory, and writing them leaves io_out_o unchanged.
- R9: A write in the same cycle as a jump uses the page in effect before the jump.
- R10: When jmp_i and step_i are both high, the jump wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 9 | Write address within the page |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 9 | Read address within the page |
| rd_data_o | output | 32 | Read data (combinational) |
| jmp_i | input | 1 | Paged jump strobe |
| jmp_page_i | input | 9 | Destination field carrying the page number |
| jmp_addr_i | input | 9 | Jump target within the page |
| step_i | input | 1 | Advance the program counter |
| pc_o | output | 9 | Program counter |
| page_o | output | 2 | Current page (width grows with NUM_PAGES) |
| fetch_data_o | output | 32 | Word at current page and pc_o |
| io_in_i | input | 32 | Input port value |
| io_out_o | output | 32 | Output register |
| io_dir_o | output | 32 | Direction register |

## Verification
The bench builds two copies that are driven by the same stimulus. The first uses the default of four pages with the window on every page. The second uses three pages with the window on page 0 only. Three pages is not a power of two, so the modulo reduction of page values 5 and 6 shows up as a different result from simple bit truncation. The page-0-only copy is written to at address 497 on page 1 while the default copy is written at the same time, so one stimulus covers both the overlay on every page and its absence.

// File: rtl/paged_regmem_pkg.sv
package paged_regmem_pkg;
  localparam int ADDR_W   = 9;
  localparam int PAGE_WORDS = 1 << ADDR_W;
  localparam int IO_IN_OFS  = 0;
  localparam int IO_OUT_OFS = 1;
  localparam int IO_DIR_OFS = 2;
  typedef logic [ADDR_W-1:0] word_addr_t;
endpackage

// File: rtl/paged_addr_xlate.sv
module paged_addr_xlate
  import paged_regmem_pkg::*;
#(
  parameter int PAGE_W      = 2,
  parameter int IO_WORDS    = 16,
  parameter bit OVERLAY_ALL = 1'b1,
  localparam int IO_IDX_W   = $clog2(IO_WORDS),
  localparam int PHYS_W     = PAGE_W + ADDR_W
) (
  input  logic [PAGE_W-1:0]   page_i,
  input  word_addr_t          addr_i,
  output logic                is_io_o,
  output logic [PHYS_W-1:0]   phys_o,
  output logic [IO_IDX_W-1:0] io_idx_o
);
  localparam int IO_BASE = PAGE_WORDS - IO_WORDS;

  logic in_win;
  assign in_win = (int'(addr_i) >= IO_BASE);

  generate
    if (OVERLAY_ALL) begin : g_all
      assign is_io_o = in_win;
    end else begin : g_p0
      assign is_io_o = in_win && (page_i == '0);
    end
  endgenerate

  assign phys_o   = {page_i, addr_i};
  assign io_idx_o = addr_i[IO_IDX_W-1:0];
endmodule

// File: rtl/paged_io_window.sv
module paged_io_window
  import paged_regmem_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IO_WORDS = 16,
  localparam int IO_IDX_W = $clog2(IO_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IO_IDX_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [IO_IDX_W-1:0] rd_idx_a_i,
  output logic [DATA_W-1:0]   rd_data_a_o,
  input  logic [IO_IDX_W-1:0] rd_idx_b_i,
  output logic [DATA_W-1:0]   rd_data_b_o,
  input  logic [DATA_W-1:0]   io_in_i,
  output logic [DATA_W-1:0]   io_out_o,
  output logic [DATA_W-1:0]   io_dir_o
);
  logic [DATA_W-1:0] regs [IO_WORDS];

  // offset 0 is the input port: not storage
  assign regs[IO_IN_OFS] = io_in_i;

  generate
    for (genvar g = 1; g < IO_WORDS; g++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  regs[g] <= '0;
        else if (wr_en_i && int'(wr_idx_i) == g)      regs[g] <= wr_data_i;
      end
    end
  endgenerate

  assign rd_data_a_o = regs[rd_idx_a_i];
  assign rd_data_b_o = regs[rd_idx_b_i];
  assign io_out_o    = regs[IO_OUT_OFS];
  assign io_dir_o    = regs[IO_DIR_OFS];
endmodule

// File: rtl/paged_pc_ctrl.sv
module paged_pc_ctrl
  import paged_regmem_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int PAGE_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              jmp_i,
  input  word_addr_t        jmp_page_i,
  input  word_addr_t        jmp_addr_i,
  input  logic              step_i,
  output logic [PAGE_W-1:0] page_o,
  output word_addr_t        pc_o
);
  word_addr_t page_mod;
  assign page_mod = jmp_page_i % ADDR_W'(NUM_PAGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      pc_o   <= '0;
    end else if (jmp_i) begin
      page_o <= page_mod[PAGE_W-1:0];
      pc_o   <= jmp_addr_i;
    end else if (step_i) begin
      pc_o   <= pc_o + 1'b1;
    end
  end
endmodule

// File: rtl/paged_regmem.sv
module paged_regmem
  import paged_regmem_pkg::*;
#(
  parameter int NUM_PAGES   = 4,
  parameter int DATA_W      = 32,
  parameter int IO_WORDS    = 16,
  parameter bit OVERLAY_ALL = 1'b1,
  localparam int PAGE_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [8:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [8:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              jmp_i,
  input  logic [8:0]        jmp_page_i,
  input  logic [8:0]        jmp_addr_i,
  input  logic              step_i,
  output logic [8:0]        pc_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [DATA_W-1:0] fetch_data_o,
  input  logic [DATA_W-1:0] io_in_i,
  output logic [DATA_W-1:0] io_out_o,
  output logic [DATA_W-1:0] io_dir_o
);
  localparam int PHYS_W    = PAGE_W + ADDR_W;
  localparam int MEM_WORDS = NUM_PAGES * PAGE_WORDS;
  localparam int IO_IDX_W  = $clog2(IO_WORDS);
  localparam int NPORT     = 3;  // 0 write, 1 read, 2 fetch

  logic                wr_io,  rd_io,  fe_io;
  logic [PHYS_W-1:0]   wr_phys, rd_phys, fe_phys;
  logic [IO_IDX_W-1:0] wr_idx, rd_idx, fe_idx;
  logic [DATA_W-1:0]   io_rd, io_fe;
  logic [DATA_W-1:0]   mem [MEM_WORDS];

  word_addr_t          x_addr  [NPORT];
  logic                x_io    [NPORT];
  logic [PHYS_W-1:0]   x_phys  [NPORT];
  logic [IO_IDX_W-1:0] x_idx   [NPORT];

  paged_pc_ctrl #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) i_pc (
    .clk_i, .rst_ni, .jmp_i, .jmp_page_i, .jmp_addr_i, .step_i,
    .page_o, .pc_o
  );

  assign x_addr[0] = wr_addr_i;
  assign x_addr[1] = rd_addr_i;
  assign x_addr[2] = pc_o;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_xl
      paged_addr_xlate #(
        .PAGE_W(PAGE_W), .IO_WORDS(IO_WORDS), .OVERLAY_ALL(OVERLAY_ALL)
      ) i_xl (
        .page_i(page_o), .addr_i(x_addr[p]),
        .is_io_o(x_io[p]), .phys_o(x_phys[p]), .io_idx_o(x_idx[p])
      );
    end
  endgenerate

  assign wr_io = x_io[0]; assign wr_phys = x_phys[0]; assign wr_idx = x_idx[0];
  assign rd_io = x_io[1]; assign rd_phys = x_phys[1]; assign rd_idx = x_idx[1];
  assign fe_io = x_io[2]; assign fe_phys = x_phys[2]; assign fe_idx = x_idx[2];

  paged_io_window #(.DATA_W(DATA_W), .IO_WORDS(IO_WORDS)) i_io (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en_i && wr_io), .wr_idx_i(wr_idx), .wr_data_i,
    .rd_idx_a_i(rd_idx), .rd_data_a_o(io_rd),
    .rd_idx_b_i(fe_idx), .rd_data_b_o(io_fe),
    .io_in_i, .io_out_o, .io_dir_o
  );

  // write uses the page held before any same-cycle jump
  always_ff @(posedge clk_i) begin
    if (wr_en_i && !wr_io) mem[wr_phys] <= wr_data_i;
  end

  assign rd_data_o    = rd_io ? io_rd : mem[rd_phys];
  assign fetch_data_o = fe_io ? io_fe : mem[fe_phys];
endmodule

// File: rtl/paged_regmem_chk.sv
module paged_regmem_chk #(
  parameter int NUM_PAGES   = 4,
  parameter int DATA_W      = 32,
  parameter bit OVERLAY_ALL = 1'b1,
  parameter int PAGE_W      = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [8:0]        wr_addr_i,
  input logic [8:0]        rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              jmp_i,
  input logic [8:0]        jmp_page_i,
  input logic [8:0]        jmp_addr_i,
  input logic              step_i,
  input logic [8:0]        pc_o,
  input logic [PAGE_W-1:0] page_o,
  input logic [DATA_W-1:0] io_in_i,
  input logic [DATA_W-1:0] io_out_o
);
  // R3 R10
  jump_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_i |=> (pc_o == $past(jmp_addr_i)) &&
              (32'(page_o) == 32'($past(jmp_page_i)) % NUM_PAGES));

  // R4
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !jmp_i) |=> (pc_o == $past(pc_o) + 9'd1) && $stable(page_o));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !jmp_i) |=> $stable(pc_o) && $stable(page_o));

  // R5
  page_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(page_o) < NUM_PAGES);

  // R7
  out_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == 9'd497) |=> $stable(io_out_o));

  // R6 R7
  in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OVERLAY_ALL && rd_addr_i == 9'd496) |-> rd_data_o == io_in_i);
endmodule

bind paged_regmem paged_regmem_chk #(
  .NUM_PAGES(NUM_PAGES), .DATA_W(DATA_W), .OVERLAY_ALL(OVERLAY_ALL), .PAGE_W(PAGE_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .jmp_i(jmp_i),
  .jmp_page_i(jmp_page_i), .jmp_addr_i(jmp_addr_i), .step_i(step_i),
  .pc_o(pc_o), .page_o(page_o), .io_in_i(io_in_i), .io_out_o(io_out_o)
);

// File: tb/test_paged_regmem.sv
module test_paged_regmem;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [8:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [8:0]  rd_addr_i = '0;
  logic        jmp_i = 1'b0;
  logic [8:0]  jmp_page_i = '0;
  logic [8:0]  jmp_addr_i = '0;
  logic        step_i = 1'b0;
  logic [31:0] io_in_i = '0;

  logic [31:0] rd_data_o, fetch_data_o, io_out_o, io_dir_o;
  logic [8:0]  pc_o;
  logic [1:0]  page_o;
  logic [31:0] rd_data_b, fetch_data_b, io_out_b, io_dir_b;
  logic [8:0]  pc_b;
  logic [1:0]  page_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  paged_regmem i_paged_regmem (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .jmp_i, .jmp_page_i, .jmp_addr_i, .step_i, .pc_o, .page_o, .fetch_data_o,
    .io_in_i, .io_out_o, .io_dir_o
  );

  paged_regmem #(.NUM_PAGES(3), .OVERLAY_ALL(1'b0)) i_paged_regmem_p0 (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o(rd_data_b),
    .jmp_i, .jmp_page_i, .jmp_addr_i, .step_i, .pc_o(pc_b), .page_o(page_b),
    .fetch_data_o(fetch_data_b), .io_in_i, .io_out_o(io_out_b), .io_dir_o(io_dir_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; jmp_i = 1'b0; step_i = 1'b0;
  endtask

  task automatic jump(input logic [8:0] pg, input logic [8:0] ad);
    jmp_i = 1'b1; jmp_page_i = pg; jmp_addr_i = ad; tick();
  endtask

  task automatic wr(input logic [8:0] ad, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = ad; wr_data_i = d; tick();
  endtask

  function automatic logic [31:0] rd(input logic [8:0] ad);
    rd_addr_i = ad;
    return 32'h0;
  endfunction

  task automatic read_main(input logic [8:0] ad, output logic [31:0] d);
    rd_addr_i = ad; #1; d = rd_data_o;
  endtask

  task automatic t_reset();
    repeat (2) @(posedge clk_i); #1;
    chk("R1 page", 32'(page_o), 0);
    chk("R1 pc", 32'(pc_o), 0);
    chk("R1 io_out", io_out_o, 0);
    chk("R1 io_dir", io_dir_o, 0);
    chk("R1 page b", 32'(page_b), 0);
    rst_ni = 1'b1; #1;
  endtask

  task automatic t_paged_rw();
    logic [31:0] d;
    jump(9'd1, 9'd0); wr(9'd20, 32'hF1F1_0001);
    jump(9'd2, 9'd0); wr(9'd20, 32'hF2F2_0002);
    read_main(9'd20, d); chk("R2 page2 word", d, 32'hF2F2_0002);
    jump(9'd1, 9'd20);
    chk("R3 page", 32'(page_o), 1);
    chk("R3 pc", 32'(pc_o), 20);
    chk("R3 fetch no bubble", fetch_data_o, 32'hF1F1_0001);
    read_main(9'd20, d); chk("R2 page1 word", d, 32'hF1F1_0001);
  endtask

  task automatic t_step();
    jump(9'd3, 9'd510);
    step_i = 1'b1; tick(); chk("R4 pc 511", 32'(pc_o), 511);
    step_i = 1'b1; tick(); chk("R4 pc wrap", 32'(pc_o), 0);
    chk("R4 page held", 32'(page_o), 3);
    tick(); chk("R4 idle hold", 32'(pc_o), 0);
    jmp_i = 1'b1; jmp_page_i = 9'd0; jmp_addr_i = 9'd7; step_i = 1'b1; tick();
    chk("R10 jump wins", 32'(pc_o), 7);
  endtask

  task automatic t_wrap();
    jump(9'd5, 9'd0);
    chk("R5 4 pages p5", 32'(page_o), 1);
    chk("R5 3 pages p5", 32'(page_b), 2);
    jump(9'd6, 9'd0);
    chk("R5 4 pages p6", 32'(page_o), 2);
    chk("R5 3 pages p6", 32'(page_b), 0);
  endtask

  task automatic t_overlay();
    logic [31:0] d;
    jump(9'd1, 9'd0); wr(9'd500, 32'hAAAA_5555);
    jump(9'd3, 9'd0);
    read_main(9'd500, d); chk("R6 shared window", d, 32'hAAAA_5555);
    wr(9'd497, 32'h0000_00C3); chk("R7 io_out", io_out_o, 32'h0000_00C3);
    wr(9'd498, 32'h0000_00FF); chk("R7 io_dir", io_dir_o, 32'h0000_00FF);
    io_in_i = 32'h1234_5678;
    read_main(9'd496, d); chk("R7 input read", d, 32'h1234_5678);
    wr(9'd496, 32'hDEAD_BEEF);
    read_main(9'd496, d); chk("R7 input write ignored", d, 32'h1234_5678);
  endtask

  task automatic t_page0_only();
    // page 3 is page 0 in the 3-page copy, so its io_out also took C3
    chk("R8 p0 io_out page0", io_out_b, 32'h0000_00C3);
    jump(9'd1, 9'd0); wr(9'd497, 32'h0000_0B0B);
    chk("R8 overlay-all io_out", io_out_o, 32'h0000_0B0B);
    chk("R8 p0 io_out unchanged", io_out_b, 32'h0000_00C3);
    rd_addr_i = 9'd497; #1;
    chk("R8 p0 plain memory", rd_data_b, 32'h0000_0B0B);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    jump(9'd2, 9'd0); wr(9'd30, 32'h5555_0002);
    jump(9'd0, 9'd0);
    wr_en_i = 1'b1; wr_addr_i = 9'd30; wr_data_i = 32'h7777_0000;
    jmp_i = 1'b1; jmp_page_i = 9'd2; jmp_addr_i = 9'd0; tick();
    read_main(9'd30, d); chk("R9 new page untouched", d, 32'h5555_0002);
    jump(9'd0, 9'd0);
    read_main(9'd30, d); chk("R9 old page written", d, 32'h7777_0000);
  endtask

  initial begin
    t_reset();
    t_paged_rw();
    t_step();
    t_wrap();
    t_overlay();
    t_page0_only();
    t_same_cycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule